// File: doc/BRIEF.md
# APB Transfer Observer

This block listens to an APB bus and never drives it. Every pin it touches is an input, so it can sit beside the master it watches or on a bus that some other master owns. On each transfer that finishes, it rebuilds a record purely from what the pins showed: the address, whether the transfer was a write, the data moved (write data for writes, read data for reads) and the slave error flag. The record goes out as a one-cycle valid strobe with its fields.

Each record also carries the number of wait states the slave inserted and a flag that is set if the address, direction or write data moved between the setup cycle and completion. A separate one-cycle pulse reports an access cycle that was not preceded by a setup cycle. Wait counts and ordering errors are what expose a master that ends its access phase after a fixed number of cycles rather than waiting for the slave.

Top module: `apb_xfer_watch`

## Requirements
- R1: A record is produced only for a clock edge at which select, enable and ready are all high, and its valid strobe is high for exactly the one cycle after that edge.
- R2: The record's data field holds the write data sampled on the completion edge when the write line was high there, and the read data sampled on that edge otherwise.
- R3: The record's address, direction and error fields are the values of the address, write and slave-error lines on the completion edge.
- R4: Edges with select and enable high and ready low produce no record, and the read data present on them never reaches a record.
- R5: The wait count of a record equals the number of edges with select and enable high and ready low since the last setup edge (select high, enable low), saturating at 2^WAIT_W-1 (255 by default).
- R6: The order error output pulses high for one cycle after any edge with select and enable high whose previous edge was neither a setup edge nor a wait edge; it is low otherwise.
- R7: The record's hold error flag is 1 when, on any access edge of the transfer, the address or write line differs from its setup-edge value, or, for a write, the write data differs; it is 0 otherwise.
- R8: After reset all outputs are 0, and record fields keep their values between strobes.
- R9: Back-to-back transfers, where a setup edge directly follows a completion edge, each give their own record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Observed peripheral select |
| bus_enable | input | 1 | Observed enable (access phase) |
| bus_ready | input | 1 | Observed slave ready |
| bus_write | input | 1 | Observed direction, 1 = write |
| bus_addr | input | ADDR_W | Observed address |
| bus_wdata | input | DATA_W | Observed write data |
| bus_rdata | input | DATA_W | Observed read data |
| bus_slverr | input | 1 | Observed slave error |
| rec_valid | output | 1 | One-cycle strobe: a record is present |
| rec_addr | output | ADDR_W | Record address |
| rec_write | output | 1 | Record direction, 1 = write |
| rec_data | output | DATA_W | Record data |
| rec_err | output | 1 | Record slave error |
| rec_waits | output | WAIT_W | Record wait-state count |
| rec_hold_err | output | 1 | Setup fields changed before completion |
| order_err | output | 1 | Access without setup, one-cycle pulse |

## Verification
Every result is registered once, so the record and the order pulse both become visible after the rising edge that sampled the triggering bus cycle and are gone after the following edge. The bench changes the bus only on falling edges and reads the outputs at the next falling edge, which is exactly the cycle in which a result for the cycle just driven is due. During wait states it reads the strobe at each falling edge to confirm nothing appears early, and one cycle after each completion it confirms the strobe has dropped.

// File: rtl/apb_watch_pkg.sv
package apb_watch_pkg;

    // Kind of bus cycle seen at a rising edge
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_WAIT  = 2'd2,
        PH_DONE  = 2'd3
    } bus_phase_e;

    function automatic bus_phase_e classify(input logic sel, input logic en, input logic rdy);
        bus_phase_e ph;
        if (!sel)      ph = PH_IDLE;
        else if (!en)  ph = PH_SETUP;
        else if (!rdy) ph = PH_WAIT;
        else           ph = PH_DONE;
        return ph;
    endfunction

    function automatic logic is_access(input bus_phase_e ph);
        return (ph == PH_WAIT) || (ph == PH_DONE);
    endfunction

endpackage

// File: rtl/apb_watch_phase.sv
module apb_watch_phase
    import apb_watch_pkg::*;
#(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              en,
    input  logic              rdy,
    output bus_phase_e        ph_now,
    output logic [WAIT_W-1:0] waits,
    output logic              order_err
);
    localparam logic [WAIT_W-1:0] WAIT_MAX = {WAIT_W{1'b1}};

    typedef struct packed {
        bus_phase_e        prev_ph;
        logic [WAIT_W-1:0] wait_cnt;
        logic              order_err;
    } phase_st_t;

    phase_st_t st_d, st_q;
    bus_phase_e ph;
    logic legal_prev;

    always_comb begin
        ph         = classify(sel, en, rdy);
        legal_prev = (st_q.prev_ph == PH_SETUP) || (st_q.prev_ph == PH_WAIT);
        st_d           = st_q;
        st_d.prev_ph   = ph;
        st_d.order_err = is_access(ph) && !legal_prev;
        if (ph == PH_SETUP) begin
            st_d.wait_cnt = '0;
        end else if (ph == PH_WAIT && st_q.wait_cnt != WAIT_MAX) begin
            st_d.wait_cnt = st_q.wait_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev_ph: PH_IDLE, wait_cnt: '0, order_err: 1'b0};
        else        st_q <= st_d;
    end

    assign ph_now    = ph;
    assign waits     = st_q.wait_cnt;
    assign order_err = st_q.order_err;

    // R5
    wait_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !en) |=> (waits == '0));

    // R6
    order_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |-> $past(sel && en));

endmodule

// File: rtl/apb_watch_hold.sv
module apb_watch_hold
    import apb_watch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_phase_e        ph_now,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic [DATA_W-1:0] wdata,
    output logic              hold_now
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic              bad;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic mism;

    always_comb begin
        mism = is_access(ph_now) &&
               ((addr != st_q.addr) || (write != st_q.write) ||
                (st_q.write && (wdata != st_q.wdata)));
        st_d = st_q;
        if (ph_now == PH_SETUP) begin
            st_d.addr  = addr;
            st_d.write = write;
            st_d.wdata = wdata;
            st_d.bad   = 1'b0;
        end else if (mism) begin
            st_d.bad = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_now = st_q.bad | mism;

    // R7
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_now == PH_SETUP) |=> !st_q.bad);

endmodule

// File: rtl/apb_xfer_watch.sv
module apb_xfer_watch
    import apb_watch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_enable,
    input  logic              bus_ready,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_slverr,
    output logic              rec_valid,
    output logic [ADDR_W-1:0] rec_addr,
    output logic              rec_write,
    output logic [DATA_W-1:0] rec_data,
    output logic              rec_err,
    output logic [WAIT_W-1:0] rec_waits,
    output logic              rec_hold_err,
    output logic              order_err
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] data;
        logic              err;
        logic [WAIT_W-1:0] waits;
        logic              hold_err;
    } rec_t;

    bus_phase_e        ph;
    logic [WAIT_W-1:0] waits_cur;
    logic              hold_cur;
    rec_t              rec_d, rec_q;

    apb_watch_phase #(.WAIT_W(WAIT_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (bus_sel),
        .en        (bus_enable),
        .rdy       (bus_ready),
        .ph_now    (ph),
        .waits     (waits_cur),
        .order_err (order_err)
    );

    apb_watch_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph_now   (ph),
        .addr     (bus_addr),
        .write    (bus_write),
        .wdata    (bus_wdata),
        .hold_now (hold_cur)
    );

    always_comb begin
        rec_d       = rec_q;
        rec_d.valid = (ph == PH_DONE);
        if (ph == PH_DONE) begin
            rec_d.addr     = bus_addr;
            rec_d.write    = bus_write;
            rec_d.data     = bus_write ? bus_wdata : bus_rdata;
            rec_d.err      = bus_slverr;
            rec_d.waits    = waits_cur;
            rec_d.hold_err = hold_cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign rec_valid    = rec_q.valid;
    assign rec_addr     = rec_q.addr;
    assign rec_write    = rec_q.write;
    assign rec_data     = rec_q.data;
    assign rec_err      = rec_q.err;
    assign rec_waits    = rec_q.waits;
    assign rec_hold_err = rec_q.hold_err;

    // R1
    rec_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> $past(bus_sel && bus_enable && bus_ready));

    // R2
    rec_data_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_data == ($past(bus_write) ? $past(bus_wdata) : $past(bus_rdata))));

    // R3
    rec_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_err == $past(bus_slverr)));

    // R8
    rec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_valid |-> ($stable(rec_addr) && $stable(rec_data)));

endmodule

// File: tb/sim_apb_xfer_watch.sv
module sim_apb_xfer_watch;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int WW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0, en = 1'b0, rdy = 1'b0, wr = 1'b0, serr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0, rdata = '0;
    logic          rec_valid, rec_write, rec_err, rec_hold_err, order_err;
    logic [AW-1:0] rec_addr;
    logic [DW-1:0] rec_data;
    logic [WW-1:0] rec_waits;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    apb_xfer_watch #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(sel), .bus_enable(en), .bus_ready(rdy), .bus_write(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_slverr(serr),
        .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_write(rec_write),
        .rec_data(rec_data), .rec_err(rec_err), .rec_waits(rec_waits),
        .rec_hold_err(rec_hold_err), .order_err(order_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        sel = 1'b0; en = 1'b0; rdy = 1'b0; serr = 1'b0;
        @(negedge clk);
        chk("R1 strobe drops", rec_valid, 0);
    endtask

    // one transfer: setup, nw wait cycles, completion; checks its record
    task automatic xfer(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] wd,
                        input logic [DW-1:0] rd, input logic e, input int nw,
                        input logic mutate, input logic idle_after);
        logic [WW-1:0] exp_w;
        exp_w = (nw > 255) ? 8'hFF : nw[WW-1:0];
        sel = 1'b1; en = 1'b0; rdy = 1'b0; addr = a; wr = w; wdata = wd;
        rdata = 32'hDEAD_0000; serr = 1'b0;
        @(negedge clk);
        en = 1'b1;
        for (int i = 0; i < nw; i++) begin
            rdata = 32'hBAD0_0000 + i;
            if (mutate && i == 0) addr = a ^ 32'h4;
            else                  addr = a;
            @(negedge clk);
            chk("R4 no record in wait", rec_valid, 0);
        end
        addr = a; rdy = 1'b1; rdata = rd; serr = e;
        @(negedge clk);
        chk("R1 strobe", rec_valid, 1);
        chk("R3 addr", rec_addr, a);
        chk("R3 dir", rec_write, w);
        chk("R2 data", rec_data, w ? wd : rd);
        chk("R3 err", rec_err, e);
        chk("R5 waits", rec_waits, exp_w);
        chk("R7 hold", rec_hold_err, mutate);
        chk("R6 no order err", order_err, 0);
        if (idle_after) go_idle();
    endtask

    task automatic t_reset();
        chk("R8 valid at reset", rec_valid, 0);
        chk("R8 data at reset", rec_data, 0);
        chk("R8 waits at reset", rec_waits, 0);
        chk("R8 order at reset", order_err, 0);
    endtask

    task automatic t_basic();
        xfer(32'h40, 1'b1, 32'hABCD, 32'h0, 1'b0, 0, 1'b0, 1'b1);
        xfer(32'h44, 1'b0, 32'h1111, 32'h5A5A_1234, 1'b0, 3, 1'b0, 1'b1);
        xfer(32'h48, 1'b0, 32'h0, 32'h0F0F_0F0F, 1'b1, 1, 1'b0, 1'b1);
        // R8 fields kept while idle
        @(negedge clk);
        chk("R8 keep data", rec_data, 32'h0F0F_0F0F);
        chk("R8 keep addr", rec_addr, 32'h48);
    endtask

    task automatic t_b2b();
        // R9
        xfer(32'h100, 1'b1, 32'h1, 32'h0, 1'b0, 0, 1'b0, 1'b0);
        xfer(32'h104, 1'b0, 32'h0, 32'h22, 1'b0, 2, 1'b0, 1'b0);
        xfer(32'h108, 1'b1, 32'h3, 32'h0, 1'b1, 0, 1'b0, 1'b1);
    endtask

    task automatic t_hold();
        xfer(32'h200, 1'b0, 32'h0, 32'h77, 1'b0, 2, 1'b1, 1'b1);
        xfer(32'h204, 1'b1, 32'h9, 32'h0, 1'b0, 1, 1'b0, 1'b1);
        // R7 write data moved during wait
        sel = 1'b1; en = 1'b0; addr = 32'h208; wr = 1'b1; wdata = 32'hAA;
        @(negedge clk);
        en = 1'b1; wdata = 32'hBB;
        @(negedge clk);
        rdy = 1'b1; wdata = 32'hAA;
        @(negedge clk);
        chk("R7 wdata moved", rec_hold_err, 1);
        chk("R2 data on completion edge", rec_data, 32'hAA);
        go_idle();
    endtask

    task automatic t_order();
        sel = 1'b1; en = 1'b1; rdy = 1'b1; addr = 32'h300; wr = 1'b0; rdata = 32'h33;
        @(negedge clk);
        chk("R6 order pulse", order_err, 1);
        chk("R1 record still made", rec_valid, 1);
        // enable stays high after completion: second violation
        rdata = 32'h34;
        @(negedge clk);
        chk("R6 order repeat", order_err, 1);
        sel = 1'b0; en = 1'b0; rdy = 1'b0;
        @(negedge clk);
        chk("R6 pulse ends", order_err, 0);
        xfer(32'h304, 1'b0, 32'h0, 32'h44, 1'b0, 1, 1'b0, 1'b1);
    endtask

    task automatic t_sat();
        xfer(32'h400, 1'b0, 32'h0, 32'h99, 1'b0, 300, 1'b0, 1'b1);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_b2b();
        t_hold();
        t_order();
        t_sat();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule